// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves a short, relative conditional jump. From a 4-bit condition selector, five status flags and a count register, it decides whether the branch is taken. It then produces the next instruction pointer: the displaced target when taken, the fall-through address otherwise. The target is limited to 16 bits when the small operand size is active, and it is checked against the code segment limit. A fault is raised when a taken target lies past that limit.

A separate count mode ignores the flags and the selector. In that mode the branch is taken when the count register is zero, so that a counted loop can be skipped when its trip count is zero. A taken, non-faulting branch raises a debug trap when trapping on taken branches is enabled. The unit only reads the flags and never alters them. All results are registered, so they appear one clock after the inputs.

Top module: `branch_resolve`

## Requirements
- R1: With count mode off, the selector bits [3:1] choose a base test: 0 overflow (OF), 1 below (CF), 2 zero (ZF), 3 below-or-equal (CF or ZF), 4 sign (SF), 5 parity (PF), 6 less (SF differs from OF), 7 less-or-equal (ZF, or SF differs from OF). Selector bit 0 inverts the base test. For example, selector 7h is taken when CF=0 and ZF=0.
- R2: When the branch is taken, the next pointer is the current pointer plus the sign-extended displacement.
- R3: When the branch is not taken, the next pointer is the current pointer plus the instruction length, which is zero-extended.
- R4: With the 16-bit operand size selected, the computed next pointer, on either path, has its upper bits cleared, keeping only bits [15:0].
- R5: With count mode on, the selector and flags are ignored. The branch is taken exactly when the count register is zero: the full 32 bits in 32-bit mode, only bits [15:0] in 16-bit mode.
- R6: A taken target strictly greater than the code segment limit sets the fault output. The next pointer then stays equal to the current pointer, and the taken output still reads 1. A target equal to the limit is legal. The fall-through address is not checked against the limit.
- R7: The debug trap output is 1 exactly when the branch is taken, the trap enable is 1, and no fault is raised.
- R8: All outputs update one clock after the inputs are presented. A synchronous active-high reset clears taken, fault and trap, and sets the next pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 4 | Condition selector (bits [3:1] base test, bit 0 invert) |
| cnt_mode | input | 1 | 1 selects the count-register-zero test |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| count_val | input | 32 | Count register value |
| disp | input | 8 | Signed displacement |
| ip_cur | input | 32 | Current instruction pointer |
| instr_len | input | 4 | Instruction length in bytes |
| op16 | input | 1 | 1 selects 16-bit operand size |
| cs_limit | input | 32 | Code segment limit (highest legal offset) |
| tb_trap_en | input | 1 | Enables the debug trap on taken branches |
| ip_next | output | 32 | Next instruction pointer |
| taken | output | 1 | Branch condition held |
| gp_fault | output | 1 | Taken target beyond the segment limit |
| dbg_trap | output | 1 | Taken-branch debug trap |

## Verification
The limit fault and the taken-branch trap can fall in the same cycle: a taken branch with the trap enabled whose target exceeds the segment limit. The bench provokes this by setting the limit one byte below the target while the trap is enabled. It expects the fault to win, with the trap low, the taken output high and the pointer held at its current value. It also places a target exactly on the limit, which must pass. A further case combines 16-bit wrap with count mode, to show that the narrowed count test and the narrowed target apply together.

// File: rtl/brres_pkg.sv
package brres_pkg;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flags_t;

    typedef enum logic [2:0] {
        CT_OVF      = 3'd0,
        CT_BELOW    = 3'd1,
        CT_ZERO     = 3'd2,
        CT_BELOW_EQ = 3'd3,
        CT_SIGN     = 3'd4,
        CT_PARITY   = 3'd5,
        CT_LESS     = 3'd6,
        CT_LESS_EQ  = 3'd7
    } cond_kind_t;

    localparam int NARROW_W = 16;

    function automatic logic base_test(cond_kind_t k, flags_t f);
        logic r;
        case (k)
            CT_OVF:      r = f.of;
            CT_BELOW:    r = f.cf;
            CT_ZERO:     r = f.zf;
            CT_BELOW_EQ: r = f.cf | f.zf;
            CT_SIGN:     r = f.sf;
            CT_PARITY:   r = f.pf;
            CT_LESS:     r = f.sf ^ f.of;
            default:     r = f.zf | (f.sf ^ f.of);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brres_cond_eval.sv
module brres_cond_eval
    import brres_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [3:0]       cond_sel,
    input  flags_t           flags,
    input  logic             cnt_mode,
    input  logic [CNT_W-1:0] count_val,
    input  logic             op16,
    output logic             take
);
    logic flag_take;
    logic cnt_zero;

    always_comb begin
        flag_take = base_test(cond_kind_t'(cond_sel[3:1]), flags) ^ cond_sel[0];
        if (op16)
            cnt_zero = (count_val[NARROW_W-1:0] == '0);
        else
            cnt_zero = (count_val == '0);
        take = cnt_mode ? cnt_zero : flag_take;
    end

endmodule

// File: rtl/brres_target_calc.sv
module brres_target_calc
    import brres_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic [ADDR_W-1:0] ip_cur,
    input  logic [DISP_W-1:0] disp,
    input  logic [LEN_W-1:0]  instr_len,
    input  logic              take,
    input  logic              op16,
    input  logic [ADDR_W-1:0] cs_limit,
    output logic [ADDR_W-1:0] next_addr,
    output logic              over_limit
);
    localparam logic [ADDR_W-1:0] MASK16 = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] len_ext;
    logic [ADDR_W-1:0] raw_sum;

    always_comb begin
        disp_ext   = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        len_ext    = {{(ADDR_W-LEN_W){1'b0}}, instr_len};
        raw_sum    = ip_cur + (take ? disp_ext : len_ext);
        next_addr  = op16 ? (raw_sum & MASK16) : raw_sum;
        over_limit = take && (next_addr > cs_limit);
    end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import brres_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        cond_sel,
    input  logic              cnt_mode,
    input  logic              flag_cf,
    input  logic              flag_zf,
    input  logic              flag_sf,
    input  logic              flag_of,
    input  logic              flag_pf,
    input  logic [ADDR_W-1:0] count_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] ip_cur,
    input  logic [LEN_W-1:0]  instr_len,
    input  logic              op16,
    input  logic [ADDR_W-1:0] cs_limit,
    input  logic              tb_trap_en,
    output logic [ADDR_W-1:0] ip_next,
    output logic              taken,
    output logic              gp_fault,
    output logic              dbg_trap
);
    flags_t            flags;
    logic              take_c;
    logic [ADDR_W-1:0] target_c;
    logic              over_c;
    logic              valid_q;

    assign flags = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of, pf: flag_pf};

    brres_cond_eval #(.CNT_W(ADDR_W)) u_cond (
        .cond_sel  (cond_sel),
        .flags     (flags),
        .cnt_mode  (cnt_mode),
        .count_val (count_val),
        .op16      (op16),
        .take      (take_c)
    );

    brres_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_tgt (
        .ip_cur     (ip_cur),
        .disp       (disp),
        .instr_len  (instr_len),
        .take       (take_c),
        .op16       (op16),
        .cs_limit   (cs_limit),
        .next_addr  (target_c),
        .over_limit (over_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_next  <= '0;
            taken    <= 1'b0;
            gp_fault <= 1'b0;
            dbg_trap <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            ip_next  <= over_c ? ip_cur : target_c;
            taken    <= take_c;
            gp_fault <= over_c;
            dbg_trap <= take_c && tb_trap_en && !over_c;
            valid_q  <= 1'b1;
        end
    end

    // R6: a faulting branch leaves the pointer where it was
    a_r6_fault_keeps_ip: assert property (@(posedge clk) disable iff (rst)
        (valid_q && gp_fault) |-> (ip_next == $past(ip_cur)));

    // R6: a completed taken branch never lands beyond the limit
    a_r6_within_limit: assert property (@(posedge clk) disable iff (rst)
        (valid_q && taken && !gp_fault) |-> (ip_next <= $past(cs_limit)));

    // R7: trap only on a taken, non-faulting branch with trapping enabled
    a_r7_trap_qualified: assert property (@(posedge clk) disable iff (rst)
        (valid_q && dbg_trap) |-> (taken && !gp_fault && $past(tb_trap_en)));

    // R4: narrow operand size keeps the pointer within 16 bits
    a_r4_wrap16: assert property (@(posedge clk) disable iff (rst)
        (valid_q && $past(op16) && !gp_fault) |-> (ip_next[ADDR_W-1:NARROW_W] == '0));

    // R5: a zero count always takes the branch in count mode
    a_r5_count_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_q && $past(cnt_mode) && ($past(count_val) == '0)) |-> taken);

endmodule

// File: tb/branch_resolve_tb.sv
module branch_resolve_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  cond_sel;
    logic        cnt_mode;
    logic        cf, zf, sf, of_f, pf;
    logic [31:0] count_val;
    logic [7:0]  disp;
    logic [31:0] ip_cur;
    logic [3:0]  instr_len;
    logic        op16;
    logic [31:0] cs_limit;
    logic        tb_en;
    logic [31:0] ip_next;
    logic        taken, gp_fault, dbg_trap;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    branch_resolve u_dut (
        .clk(clk), .rst(rst), .cond_sel(cond_sel), .cnt_mode(cnt_mode),
        .flag_cf(cf), .flag_zf(zf), .flag_sf(sf), .flag_of(of_f), .flag_pf(pf),
        .count_val(count_val), .disp(disp), .ip_cur(ip_cur), .instr_len(instr_len),
        .op16(op16), .cs_limit(cs_limit), .tb_trap_en(tb_en),
        .ip_next(ip_next), .taken(taken), .gp_fault(gp_fault), .dbg_trap(dbg_trap)
    );

    task automatic set_base();
        cond_sel = 4'h7; cnt_mode = 0; {cf, zf, sf, of_f, pf} = 5'b0;
        count_val = 32'h5; disp = 8'h10; ip_cur = 32'h1000; instr_len = 4'd2;
        op16 = 0; cs_limit = 32'hFFFF_FFFF; tb_en = 0;
    endtask

    // waits for the registered result of the inputs currently applied
    task automatic expect_out(string req, logic [31:0] e_ip, logic e_tk, logic e_gf, logic e_tr);
        @(negedge clk);
        n_chk++;
        if (ip_next !== e_ip || taken !== e_tk || gp_fault !== e_gf || dbg_trap !== e_tr) begin
            n_bad++;
            $display("FAIL %s: got ip=%h tk=%b gf=%b tr=%b, expected ip=%h tk=%b gf=%b tr=%b",
                     req, ip_next, taken, gp_fault, dbg_trap, e_ip, e_tk, e_gf, e_tr);
        end
    endtask

    task automatic t_reset();
        set_base(); tb_en = 1; rst = 1;
        expect_out("R8 reset clears", 32'h0, 0, 0, 0);
        rst = 0;
        expect_out("R8 one-cycle latency", 32'h1010, 1, 0, 1);
        tb_en = 0;
    endtask

    task automatic t_conditions();
        set_base();
        expect_out("R1 above taken", 32'h1010, 1, 0, 0);
        cf = 1;
        expect_out("R1 above not taken", 32'h1002, 0, 0, 0);
        cond_sel = 4'h6;
        expect_out("R1 below-or-equal taken", 32'h1010, 1, 0, 0);
        set_base(); cond_sel = 4'hC; sf = 1;
        expect_out("R1 less taken", 32'h1010, 1, 0, 0);
        cond_sel = 4'hD;
        expect_out("R1 greater-or-equal not taken", 32'h1002, 0, 0, 0);
        set_base(); cond_sel = 4'hE; zf = 1;
        expect_out("R1 less-or-equal via zf", 32'h1010, 1, 0, 0);
        cond_sel = 4'hF;
        expect_out("R1 greater not taken", 32'h1002, 0, 0, 0);
        set_base(); cond_sel = 4'hA; pf = 1;
        expect_out("R1 parity taken", 32'h1010, 1, 0, 0);
        cond_sel = 4'hB;
        expect_out("R1 no-parity not taken", 32'h1002, 0, 0, 0);
        set_base(); cond_sel = 4'h0; of_f = 1;
        expect_out("R1 overflow taken", 32'h1010, 1, 0, 0);
        set_base(); cond_sel = 4'h8; sf = 1;
        expect_out("R1 sign taken", 32'h1010, 1, 0, 0);
        set_base(); cond_sel = 4'h2; cf = 1;
        expect_out("R1 below taken", 32'h1010, 1, 0, 0);
        set_base(); cond_sel = 4'h5; zf = 1;
        expect_out("R1 not-zero not taken", 32'h1002, 0, 0, 0);
    endtask

    task automatic t_targets();
        set_base(); disp = 8'hF0;
        expect_out("R2 negative displacement", 32'h0FF0, 1, 0, 0);
        disp = 8'h7F;
        expect_out("R2 max positive displacement", 32'h107F, 1, 0, 0);
        set_base(); cf = 1; instr_len = 4'hF;
        expect_out("R3 fall-through length", 32'h100F, 0, 0, 0);
    endtask

    task automatic t_wrap16();
        set_base(); op16 = 1; ip_cur = 32'hFFFE; disp = 8'h04;
        expect_out("R4 taken wraps", 32'h0002, 1, 0, 0);
        ip_cur = 32'h0004; disp = 8'hF0;
        expect_out("R4 negative wraps", 32'hFFF4, 1, 0, 0);
        cf = 1; ip_cur = 32'hFFFF; instr_len = 4'd3;
        expect_out("R4 fall-through wraps", 32'h0002, 0, 0, 0);
    endtask

    task automatic t_count();
        set_base(); cnt_mode = 1; count_val = 32'h0; cf = 1;
        expect_out("R5 zero count ignores flags", 32'h1010, 1, 0, 0);
        count_val = 32'h0001_0000;
        expect_out("R5 full-width count nonzero", 32'h1002, 0, 0, 0);
        op16 = 1;
        expect_out("R5 low16 count zero", 32'h1010, 1, 0, 0);
        op16 = 0; cf = 0; count_val = 32'h1;
        expect_out("R5 nonzero count ignores true flags", 32'h1002, 0, 0, 0);
    endtask

    task automatic t_limit_and_trap();
        set_base(); cs_limit = 32'h1010;
        expect_out("R6 target on limit legal", 32'h1010, 1, 0, 0);
        tb_en = 1; disp = 8'h11;
        expect_out("R6 R7 fault beats trap", 32'h1000, 1, 1, 0);
        set_base(); cs_limit = 32'h1000; cf = 1;
        expect_out("R6 fall-through unchecked", 32'h1002, 0, 0, 0);
        set_base(); tb_en = 1;
        expect_out("R7 trap on taken", 32'h1010, 1, 0, 1);
        cf = 1;
        expect_out("R7 no trap on not taken", 32'h1002, 0, 0, 0);
        cf = 0; tb_en = 0;
        expect_out("R7 no trap when disabled", 32'h1010, 1, 0, 0);
    endtask

    task automatic t_mid_reset();
        set_base(); tb_en = 1; rst = 1;
        expect_out("R8 mid-run reset clears", 32'h0, 0, 0, 0);
        rst = 0;
    endtask

    initial begin
        set_base(); rst = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_conditions();
        t_targets();
        t_wrap16();
        t_count();
        t_limit_and_trap();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule